// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This engine moves pixel or command traffic between 32-bit FIFO words and a slow parallel panel bus. Each transfer is configured before it starts. The configuration sets the total number of bus cycles, whether the cycles are reads or writes, whether they are command or data cycles, a bus width of 8 or 16 bits, and two phase lengths. The phase lengths are counted in functional ticks. A tick is the core clock divided by a value from 1 to 8.

Every bus cycle follows the same pattern:

- The cycle opens with one idle tick.
- The strobe is then held low for the strobe phase.
- The cycle ends with a recovery stretch.

On writes, each FIFO word is sliced least-significant part first, giving four byte cycles or two halfword cycles. On reads, the bus samples are packed back into words the same way and pushed out.

When a write word is not available, the engine waits with the strobe high. A status output tells software when no write cycles remain, so that a read can safely follow.

Top module: `lcd_bus_engine`

## Requirements
- R1: In 8-bit mode each write word gives four cycles. The cycles carry bits 7:0, then 15:8, then 23:16, then 31:24 on `bus_dout[7:0]`, with `bus_dout[15:8]` at zero. The data lines are stable while the write strobe is low.
- R2: In 16-bit mode (`cfg_wide`=1) each write word gives two cycles, carrying bits 15:0 first and then bits 31:16 on `bus_dout`.
- R3: `bus_cd` equals `cfg_data` (0 = command, 1 = data) for the whole transfer.
- R4: A tick lasts `cfg_div_m1`+1 clocks. A cycle lasts (`cfg_strobe_m1`+1)+(`cfg_recov_m1`+1) ticks. The strobe goes low one tick after the cycle begins and stays low for `cfg_strobe_m1`+1 ticks.
- R5: If the write FIFO is empty when a new word is needed, no strobe is issued. Chip select stays low and the transfer resumes once a word arrives.
- R6: A start with `cfg_recov_m1` below 2 (recovery shorter than 3 ticks) is ignored. The engine stays idle, chip select stays high and no FIFO word is taken.
- R7: In read mode, `bus_din` is sampled on the last strobe-low tick and packed least-significant slice first. A full word is pushed on `rf_push`/`rf_data`.
- R8: The final read cycle pushes the word even if it is only partly filled. Unfilled bits read as zero.
- R9: `write_done` is 1 after reset, in idle and during reads. It is 0 from the start of a write transfer until its last cycle ends.
- R10: Exactly `cfg_cycles_m1`+1 cycles are issued and then the engine returns to idle with `bus_cs_n`=1. Reset leaves all strobes and chip select high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the current configuration |
| cfg_read | input | 1 | 1 = read cycles, 0 = write cycles |
| cfg_data | input | 1 | Command/data level driven on `bus_cd` |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_strobe_m1 | input | 4 | Strobe-low ticks minus one |
| cfg_recov_m1 | input | 6 | Recovery ticks minus one, at least 2 |
| cfg_cycles_m1 | input | 18 | Bus cycles minus one |
| cfg_div_m1 | input | 3 | Clocks per tick minus one |
| wf_valid | input | 1 | Write FIFO holds a word |
| wf_data | input | 32 | Head word of the write FIFO |
| wf_pop | output | 1 | Take the head word |
| rf_push | output | 1 | Read word valid for one clock |
| rf_data | output | 32 | Packed read word |
| busy | output | 1 | Transfer in progress |
| write_done | output | 1 | No write cycles pending |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_cd | output | 1 | Command/data line |
| bus_oe | output | 1 | Engine drives the data lines |
| bus_dout | output | 16 | Data lines driven on writes |
| bus_din | input | 16 | Data lines sampled on reads |

## Verification
The first strobe edge of a write is not timed, because it depends on when a FIFO word is taken. Every later strobe fall within the same word follows the previous one by exactly (S+R)·D clocks. Each low pulse lasts S·D clocks, where S, R and D are the strobe, recovery and divide values. A packed read word appears on `rf_push` one clock after the tick that ends the cycle holding its last slice. `busy` and `write_done` settle one clock after `start` is taken.

All outputs are sampled on the falling clock edge. A monitor stamps every strobe edge with a clock count and compares pulse widths and spacings against these formulas. Each strobe fall and each pushed word is matched against the next entry that the driver queued for it.

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 18,
  parameter int STB_W  = 4,
  parameter int REC_W  = 6,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_read,
  input  logic              cfg_data,
  input  logic              cfg_wide,
  input  logic [STB_W-1:0]  cfg_strobe_m1,
  input  logic [REC_W-1:0]  cfg_recov_m1,
  input  logic [CNT_W-1:0]  cfg_cycles_m1,
  input  logic [DIV_W-1:0]  cfg_div_m1,
  input  logic              wf_valid,
  input  logic [WORD_W-1:0] wf_data,
  output logic              wf_pop,
  output logic              rf_push,
  output logic [WORD_W-1:0] rf_data,
  output logic              busy,
  output logic              write_done,
  output logic              bus_cs_n,
  output logic              bus_wr_n,
  output logic              bus_rd_n,
  output logic              bus_cd,
  output logic              bus_oe,
  output logic [15:0]       bus_dout,
  input  logic [15:0]       bus_din
);

  localparam int N8   = WORD_W / 8;
  localparam int N16  = WORD_W / 16;
  localparam int SL_W = $clog2(N8);
  localparam int PH_W = REC_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} st_t;

  st_t               st;
  logic              rd_q, cd_q, wide_q;
  logic [STB_W-1:0]  stb_q;
  logic [REC_W-1:0]  rec_q;
  logic [DIV_W-1:0]  div_q, dcnt;
  logic [PH_W-1:0]   ph;
  logic [SL_W-1:0]   slice;
  logic [CNT_W-1:0]  left;
  logic [WORD_W-1:0] word_q, rword, rf_data_q;
  logic              rf_push_q;

  logic [PH_W-1:0] stb_len, last_ph;
  logic            tick, strobe_on, last_slice, start_ok;

  assign stb_len    = PH_W'(stb_q) + PH_W'(1);
  assign last_ph    = PH_W'(stb_q) + PH_W'(rec_q) + PH_W'(1);
  assign tick       = (st == ST_RUN) && (dcnt == div_q);
  assign strobe_on  = (st == ST_RUN) && (ph != '0) && (ph <= stb_len);
  assign last_slice = wide_q ? (slice == SL_W'(N16 - 1)) : (slice == SL_W'(N8 - 1));
  assign start_ok   = start && (st == ST_IDLE) && (cfg_recov_m1 >= REC_W'(2));

  assign busy       = (st != ST_IDLE);
  assign write_done = !(busy && !rd_q);
  assign wf_pop     = (st == ST_LOAD) && wf_valid;
  assign bus_cs_n   = !busy;
  assign bus_wr_n   = !(strobe_on && !rd_q);
  assign bus_rd_n   = !(strobe_on && rd_q);
  assign bus_cd     = busy ? cd_q : 1'b1;
  assign bus_oe     = (st == ST_RUN) && !rd_q;
  assign rf_push    = rf_push_q;
  assign rf_data    = rf_data_q;

  always_comb begin
    bus_dout = '0;
    if (bus_oe) begin
      if (wide_q) begin
        for (int i = 0; i < N16; i++)
          if (slice == SL_W'(i)) bus_dout = word_q[16*i +: 16];
      end else begin
        for (int i = 0; i < N8; i++)
          if (slice == SL_W'(i)) bus_dout[7:0] = word_q[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rd_q      <= 1'b0;
      cd_q      <= 1'b1;
      wide_q    <= 1'b0;
      stb_q     <= '0;
      rec_q     <= '0;
      div_q     <= '0;
      dcnt      <= '0;
      ph        <= '0;
      slice     <= '0;
      left      <= '0;
      word_q    <= '0;
      rword     <= '0;
      rf_data_q <= '0;
      rf_push_q <= 1'b0;
    end else begin
      rf_push_q <= 1'b0;
      case (st)
        ST_IDLE: if (start_ok) begin
          rd_q   <= cfg_read;
          cd_q   <= cfg_data;
          wide_q <= cfg_wide;
          stb_q  <= cfg_strobe_m1;
          rec_q  <= cfg_recov_m1;
          div_q  <= cfg_div_m1;
          left   <= cfg_cycles_m1;
          slice  <= '0;
          ph     <= '0;
          dcnt   <= '0;
          rword  <= '0;
          st     <= cfg_read ? ST_RUN : ST_LOAD;
        end
        ST_LOAD: if (wf_valid) begin
          word_q <= wf_data;
          ph     <= '0;
          dcnt   <= '0;
          st     <= ST_RUN;
        end
        ST_RUN: begin
          dcnt <= tick ? '0 : dcnt + DIV_W'(1);
          if (tick) begin
            if (rd_q && ph == stb_len) begin
              if (wide_q) begin
                for (int i = 0; i < N16; i++)
                  if (slice == SL_W'(i)) rword[16*i +: 16] <= bus_din;
              end else begin
                for (int i = 0; i < N8; i++)
                  if (slice == SL_W'(i)) rword[8*i +: 8] <= bus_din[7:0];
              end
            end
            if (ph == last_ph) begin
              ph <= '0;
              if (rd_q && (last_slice || left == '0)) begin
                rf_push_q <= 1'b1;
                rf_data_q <= rword;
                rword     <= '0;
              end
              if (left == '0) begin
                st <= ST_IDLE;
              end else begin
                left  <= left - CNT_W'(1);
                slice <= last_slice ? '0 : slice + SL_W'(1);
                if (!rd_q && last_slice) st <= ST_LOAD;
              end
            end else begin
              ph <= ph + PH_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_dout));

  // R4
  lead_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wf_pop |=> bus_wr_n);

  // R10
  cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $past(!bus_cs_n));

  // R6
  bad_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_recov_m1 < REC_W'(2)) |=> !busy);

  // R9
  wr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !write_done);

  // R7
  push_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_push |-> write_done);

endmodule

// File: tb/lcd_bus_engine_tb.sv
`timescale 1ns/1ps
module lcd_bus_engine_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, cfg_read, cfg_data, cfg_wide;
  logic [3:0]  cfg_strobe_m1;
  logic [5:0]  cfg_recov_m1;
  logic [17:0] cfg_cycles_m1;
  logic [2:0]  cfg_div_m1;
  logic        wf_valid = 1'b0;
  logic [31:0] wf_data = '0;
  logic        wf_pop, rf_push, busy, write_done;
  logic [31:0] rf_data;
  logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_cd, bus_oe;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;

  lcd_bus_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_read(cfg_read),
    .cfg_data(cfg_data), .cfg_wide(cfg_wide), .cfg_strobe_m1(cfg_strobe_m1),
    .cfg_recov_m1(cfg_recov_m1), .cfg_cycles_m1(cfg_cycles_m1),
    .cfg_div_m1(cfg_div_m1), .wf_valid(wf_valid), .wf_data(wf_data),
    .wf_pop(wf_pop), .rf_push(rf_push), .rf_data(rf_data), .busy(busy),
    .write_done(write_done), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_cd(bus_cd), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din));

  typedef struct { logic [15:0] d; bit cd; bit first; } item_t;

  int n_cmp = 0, n_bad = 0;
  item_t       eq[$];
  logic [31:0] rq[$];
  logic [31:0] wq[$];
  bit  feed_en = 1'b0;
  int  exp_w = 0, exp_p = 0;
  int  clk_cnt = 0, wr_falls = 0, rd_falls = 0, rk = 0;
  int  last_fall = 0, low_start = 0;
  bit  prev_wr = 1'b1, prev_rd = 1'b1;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] pat(int k);
    return 16'(32'hC3A5 ^ (k * 32'h1357));
  endfunction

  always @(posedge clk) if (wf_pop && wq.size() > 0) void'(wq.pop_front());

  always @(negedge clk) begin
    wf_valid = feed_en && (wq.size() > 0);
    wf_data  = (wq.size() > 0) ? wq[0] : 32'h0;
  end

  always @(negedge clk) begin
    clk_cnt++;
    if (prev_wr && !bus_wr_n) begin
      wr_falls++;
      if (eq.size() == 0) chk(1'b0, "R10 extra write strobe", wr_falls, 0);
      else begin
        item_t it;
        it = eq.pop_front();
        chk(bus_dout == it.d, "R1/R2 write slice", bus_dout, it.d);
        chk(bus_cd == it.cd, "R3 command/data line", bus_cd, it.cd);
        if (!it.first) chk(clk_cnt - last_fall == exp_p, "R4 cycle period", clk_cnt - last_fall, exp_p);
      end
      last_fall = clk_cnt;
      low_start = clk_cnt;
    end
    if (!prev_wr && bus_wr_n)
      chk(clk_cnt - low_start == exp_w, "R4 strobe width", clk_cnt - low_start, exp_w);
    if (prev_rd && !bus_rd_n) begin
      rd_falls++;
      bus_din = pat(rk);
      rk++;
    end
    if (rf_push) begin
      if (rq.size() == 0) chk(1'b0, "R7 extra read push", rf_data, 0);
      else begin
        logic [31:0] e;
        e = rq.pop_front();
        chk(rf_data == e, "R7/R8 read word", rf_data, e);
      end
    end
    prev_wr = bus_wr_n;
    prev_rd = bus_rd_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R10 watchdog expired", 0, 1);
    finish_run();
  end

  task automatic kick(bit rd, bit cd, bit wide, int s_m1, int r_m1, int d_m1, int ncyc);
    @(negedge clk);
    cfg_read = rd; cfg_data = cd; cfg_wide = wide;
    cfg_strobe_m1 = 4'(s_m1); cfg_recov_m1 = 6'(r_m1);
    cfg_div_m1 = 3'(d_m1); cfg_cycles_m1 = 18'(ncyc - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_write(bit wide, bit cd, int s_m1, int r_m1, int d_m1, int ncyc, bit stall);
    int per = wide ? 2 : 4;
    int nw = (ncyc + per - 1) / per;
    logic [31:0] words[$];
    int f0;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] v;
      v = 32'h8E3F_1A60 ^ 32'(w * 32'h0102_0304) ^ 32'(ncyc * 32'h1111);
      words.push_back(v);
      wq.push_back(v);
    end
    for (int k = 0; k < ncyc; k++) begin
      item_t it;
      logic [31:0] v;
      v = words[k / per];
      it.d = wide ? v[16*(k%per) +: 16] : {8'h00, v[8*(k%per) +: 8]};
      it.cd = cd;
      it.first = ((k % per) == 0);
      eq.push_back(it);
    end
    exp_w = (s_m1 + 1) * (d_m1 + 1);
    exp_p = (s_m1 + r_m1 + 2) * (d_m1 + 1);
    feed_en = !stall;
    f0 = wr_falls;
    kick(1'b0, cd, wide, s_m1, r_m1, d_m1, ncyc);
    chk(write_done == 1'b0, "R9 write_done low during write", write_done, 0);
    chk(bus_cs_n == 1'b0, "R10 chip select low", bus_cs_n, 0);
    if (stall) begin
      repeat (40) @(negedge clk);
      chk(wr_falls == f0, "R5 no strobe while FIFO empty", wr_falls - f0, 0);
      chk(busy && !bus_cs_n, "R5 held selected while stalled", {busy, bus_cs_n}, 2'b10);
      feed_en = 1'b1;
    end
    wait_idle();
    chk(eq.size() == 0, "R10 all cycles issued", eq.size(), 0);
    chk(wr_falls - f0 == ncyc, "R10 strobe count", wr_falls - f0, ncyc);
    chk(wq.size() == 0, "R10 words consumed", wq.size(), 0);
    chk(write_done == 1'b1, "R9 write_done high after write", write_done, 1);
    chk(bus_cs_n == 1'b1, "R10 chip select released", bus_cs_n, 1);
  endtask

  task automatic run_read(bit wide, int s_m1, int r_m1, int d_m1, int ncyc);
    int per = wide ? 2 : 4;
    logic [31:0] cur = '0;
    int f0 = rd_falls;
    for (int k = 0; k < ncyc; k++) begin
      logic [15:0] p;
      p = pat(k);
      if (wide) cur[16*(k%per) +: 16] = p;
      else cur[8*(k%per) +: 8] = p[7:0];
      if ((k % per) == per - 1 || k == ncyc - 1) begin
        rq.push_back(cur);
        cur = '0;
      end
    end
    rk = 0;
    kick(1'b1, 1'b1, wide, s_m1, r_m1, d_m1, ncyc);
    chk(write_done == 1'b1, "R9 write_done high during read", write_done, 1);
    wait_idle();
    chk(rq.size() == 0, "R7/R8 all read words pushed", rq.size(), 0);
    chk(rd_falls - f0 == ncyc, "R10 read strobe count", rd_falls - f0, ncyc);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_read = 1'b0; cfg_data = 1'b1; cfg_wide = 1'b0;
    cfg_strobe_m1 = '0; cfg_recov_m1 = 6'd2; cfg_cycles_m1 = '0; cfg_div_m1 = '0;
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_wr_n && bus_rd_n, "R10 reset bus idle", {bus_cs_n, bus_wr_n, bus_rd_n}, 3'b111);
    chk(write_done == 1'b1 && busy == 1'b0, "R9 reset status", {write_done, busy}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_write(1'b0, 1'b1, 1, 2, 0, 8, 1'b0);
    run_write(1'b1, 1'b0, 3, 4, 2, 5, 1'b0);
    run_write(1'b0, 1'b1, 0, 2, 1, 6, 1'b1);
    run_write(1'b1, 1'b1, 15, 63, 0, 3, 1'b0);

    wq.push_back(32'hDEAD_BEEF);
    feed_en = 1'b1;
    kick(1'b0, 1'b1, 1'b0, 1, 1, 0, 4);
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R6 short recovery start ignored", busy, 0);
    chk(bus_cs_n == 1'b1, "R6 chip select stays high", bus_cs_n, 1);
    chk(wq.size() == 1, "R6 no word taken", wq.size(), 1);
    wq.delete();

    run_read(1'b0, 1, 2, 0, 6);
    run_read(1'b1, 2, 3, 1, 4);
    run_read(1'b1, 0, 2, 0, 3);

    finish_run();
  end

endmodule